// File: doc/BRIEF.md
# Skip-Symbol Rate Match FIFO

This block is an elastic buffer for a serial receiver. On one side, symbols that are already aligned arrive on the recovered clock, one symbol per cycle, each with a control flag. On the other side, they are read out on the local receive clock. The two clocks have the same nominal rate but may differ by a few hundred ppm. The buffer keeps its fill level near the middle in two ways. When the write side is running ahead and the buffer is filling up, it drops incoming skip symbols. When the read side is running ahead and the buffer is running low, it outputs an extra skip symbol.

Exactly one symbol value counts as a skip: the control flag is set and the data equals the `SKIP_SYM` parameter. Every other symbol passes through unchanged and in order. That includes control symbols with other values and data symbols whose value happens to equal the skip code. Each insertion or deletion produces a one-cycle pulse in the clock domain where it happens. If the buffer becomes full or empty despite this compensation, a sticky error flag is set and stays set until reset.

The two pointers cross between the clock domains in Gray code, through two-flop synchronizers. At start-up the read side stays idle until the buffer has filled to its midpoint.

Top module: `skip_rate_match`

## Requirements
- R1: While `rst_ni` is low, `rd_valid_o`, `ins_o`, `del_o`, `ovf_o` and `unf_o` are all 0.
- R2: Every symbol that is not a skip appears at the read side exactly once. Its data and control flag are unchanged, and the order of these symbols matches the order in which they were written.
- R3: A symbol counts as a skip only when `wr_ctrl_i`=1 and `wr_data_i`=`SKIP_SYM`. No other symbol is ever deleted, and no other symbol is ever inserted.
- R4: An incoming skip is discarded, not written, when the write-side occupancy is at or above `HI_TH`. `del_o` pulses high for one write-clock cycle, in the cycle after the skip was presented.
- R5: A skip is repeated on the output without advancing the read pointer when all of these hold: the read-side occupancy is at or above 1 and at or below `LO_TH`, the symbol at the head of the buffer is a skip, and that skip has not already been repeated. `ins_o` goes high in the same cycle as the repeated skip on the outputs.
- R6: After reset, `rd_valid_o` stays 0 until the read-side occupancy reaches `DEPTH/2`. From then on, the read side outputs one symbol per cycle.
- R7: If the buffer holds `DEPTH` entries, an arriving symbol is dropped and `ovf_o` is set. `ovf_o` stays 1 until reset.
- R8: Once reading has started, a read cycle that finds the buffer empty drives `rd_valid_o` to 0 and sets `unf_o`. `unf_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered clock (write side) |
| rd_clk_i | input | 1 | Local receive clock (read side) |
| rst_ni | input | 1 | Active-low asynchronous reset, shared by both domains |
| wr_data_i | input | 8 | Aligned symbol data, one per write cycle |
| wr_ctrl_i | input | 1 | Control flag of the incoming symbol |
| rd_data_o | output | 8 | Output symbol data |
| rd_ctrl_o | output | 1 | Control flag of the output symbol |
| rd_valid_o | output | 1 | Output symbol is present this cycle |
| ins_o | output | 1 | One-cycle pulse (read domain): a skip was inserted |
| del_o | output | 1 | One-cycle pulse (write domain): a skip was deleted |
| ovf_o | output | 1 | Sticky: a symbol was lost because the buffer was full |
| unf_o | output | 1 | Sticky: the read side found the buffer empty |

## Verification
The assertions assume that the input is a continuous stream with one symbol in every write cycle, and that both clocks toggle during reset, so that the synchronizers come up cleared. They also assume a single reset that covers both domains. The bench always drives a symbol, including idle skips between phases, and it only applies or releases reset while both clocks are running. To make drift visible within a few thousand cycles, the offsets used are larger than a real link would have: 0.5 % for the compensated phases and 10 % for the phases that have no skips at all. The compensated phases place a skip every ten symbols, which gives the buffer enough opportunities to absorb that drift.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int SYM_DW = 8;

  typedef struct packed {
    logic              ctrl;
    logic [SYM_DW-1:0] data;
  } sym_t;

  function automatic logic sym_is(sym_t s, logic [SYM_DW-1:0] code);
    return s.ctrl && (s.data == code);
  endfunction
endpackage

// File: rtl/rm_ptr_xfer.sv
// Gray-coded pointer handoff: gray register in source domain, two flops in destination.
module rm_ptr_xfer #(
  parameter int PW = 6
) (
  input  logic          src_clk_i,
  input  logic          dst_clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] bin_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] gray_q, sync1_q, sync2_q;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);

  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_q;
      sync2_q <= sync1_q;
    end

  always_comb begin
    bin_o[PW-1] = sync2_q[PW-1];
    for (int i = PW-2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ sync2_q[i];
  end
endmodule

// File: rtl/rm_wr_ctrl.sv
module rm_wr_ctrl
  import rm_pkg::*;
#(
  parameter int              AW       = 5,
  parameter int              HI_TH    = 22,
  parameter logic [SYM_DW-1:0] SKIP_SYM = 8'h1C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  sym_t        sym_i,
  input  logic [AW:0] rptr_i,
  output logic [AW:0] wptr_o,
  output logic [AW:0] occ_o,
  output logic        we_o,
  output logic        del_o,
  output logic        ovf_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HI_L   = PW'(HI_TH);
  localparam logic [PW-1:0] FULL_L = PW'(1 << AW);

  logic [PW-1:0] wptr_q;
  logic          is_skip, drop, full;

  assign occ_o   = wptr_q - rptr_i;
  assign is_skip = sym_is(sym_i, SKIP_SYM);
  assign drop    = is_skip && (occ_o >= HI_L);
  assign full    = (occ_o == FULL_L);
  assign we_o    = !drop && !full;
  assign wptr_o  = wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q <= '0;
      del_o  <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (we_o) wptr_q <= wptr_q + 1'b1;
      del_o <= drop;
      if (!drop && full) ovf_o <= 1'b1;
    end
endmodule

// File: rtl/rm_rd_ctrl.sv
module rm_rd_ctrl
  import rm_pkg::*;
#(
  parameter int              AW       = 5,
  parameter int              LO_TH    = 10,
  parameter logic [SYM_DW-1:0] SKIP_SYM = 8'h1C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [AW:0] wptr_i,
  input  sym_t        head_i,
  output logic [AW:0] rptr_o,
  output logic [AW:0] occ_o,
  output sym_t        sym_o,
  output logic        valid_o,
  output logic        ins_o,
  output logic        unf_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] LO_L  = PW'(LO_TH);
  localparam logic [PW-1:0] MID_L = PW'(1 << (AW - 1));

  logic [PW-1:0] rptr_q;
  logic          started_q, rep_done_q;
  logic          empty, do_ins, do_pop;

  assign occ_o  = wptr_i - rptr_q;
  assign empty  = (occ_o == '0);
  assign do_ins = started_q && !empty && sym_is(head_i, SKIP_SYM)
                  && (occ_o <= LO_L) && !rep_done_q;
  assign do_pop = started_q && !empty && !do_ins;
  assign rptr_o = rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_q     <= '0;
      started_q  <= 1'b0;
      rep_done_q <= 1'b0;
      sym_o      <= '0;
      valid_o    <= 1'b0;
      ins_o      <= 1'b0;
      unf_o      <= 1'b0;
    end else begin
      if (occ_o >= MID_L) started_q <= 1'b1;
      if (do_pop) rptr_q <= rptr_q + 1'b1;
      // one repeat per skip at the head
      if (do_ins)      rep_done_q <= 1'b1;
      else if (do_pop) rep_done_q <= 1'b0;
      valid_o <= do_ins || do_pop;
      sym_o   <= (do_ins || do_pop) ? head_i : '0;
      ins_o   <= do_ins;
      if (started_q && empty) unf_o <= 1'b1;
    end
endmodule

// File: rtl/skip_rate_match.sv
module skip_rate_match
  import rm_pkg::*;
#(
  parameter int              DEPTH    = 32,
  parameter int              LO_TH    = 10,
  parameter int              HI_TH    = 22,
  parameter logic [SYM_DW-1:0] SKIP_SYM = 8'h1C
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [SYM_DW-1:0] wr_data_i,
  input  logic              wr_ctrl_i,
  output logic [SYM_DW-1:0] rd_data_o,
  output logic              rd_ctrl_o,
  output logic              rd_valid_o,
  output logic              ins_o,
  output logic              del_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  sym_t          wr_sym, head, rd_sym;
  sym_t          mem_q [DEPTH];
  logic [PW-1:0] wptr, rptr, wptr_rd, rptr_wr, wr_occ, rd_occ;
  logic          we;

  assign wr_sym = '{ctrl: wr_ctrl_i, data: wr_data_i};

  rm_wr_ctrl #(.AW(AW), .HI_TH(HI_TH), .SKIP_SYM(SKIP_SYM)) u_wr (
    .clk_i (wr_clk_i), .rst_ni, .sym_i(wr_sym), .rptr_i(rptr_wr),
    .wptr_o(wptr), .occ_o(wr_occ), .we_o(we), .del_o, .ovf_o
  );

  always_ff @(posedge wr_clk_i)
    if (we) mem_q[wptr[AW-1:0]] <= wr_sym;

  assign head = mem_q[rptr[AW-1:0]];

  rm_ptr_xfer #(.PW(PW)) u_w2r (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni, .bin_i(wptr), .bin_o(wptr_rd)
  );
  rm_ptr_xfer #(.PW(PW)) u_r2w (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni, .bin_i(rptr), .bin_o(rptr_wr)
  );

  rm_rd_ctrl #(.AW(AW), .LO_TH(LO_TH), .SKIP_SYM(SKIP_SYM)) u_rd (
    .clk_i (rd_clk_i), .rst_ni, .wptr_i(wptr_rd), .head_i(head),
    .rptr_o(rptr), .occ_o(rd_occ), .sym_o(rd_sym), .valid_o(rd_valid_o),
    .ins_o, .unf_o
  );

  assign rd_data_o = rd_sym.data;
  assign rd_ctrl_o = rd_sym.ctrl;
endmodule

// File: rtl/skip_rate_match_chk.sv
module skip_rate_match_chk #(
  parameter int          PW    = 6,
  parameter int          DEPTH = 32,
  parameter int          LO_TH = 10,
  parameter int          HI_TH = 22,
  parameter logic [7:0]  SKIP  = 8'h1C
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic [7:0]    wr_data_i,
  input logic          wr_ctrl_i,
  input logic [7:0]    rd_data_i,
  input logic          rd_ctrl_i,
  input logic          rd_valid_i,
  input logic          ins_i,
  input logic          del_i,
  input logic          ovf_i,
  input logic          unf_i,
  input logic [PW-1:0] wr_occ_i,
  input logic [PW-1:0] rd_occ_i
);
  AST_DEL_ONLY_SKIP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    del_i |-> $past(wr_ctrl_i && wr_data_i == SKIP)); // R3
  AST_DEL_ABOVE_TH: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    del_i |-> $past(wr_occ_i >= PW'(HI_TH))); // R4
  AST_INS_IS_SKIP: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    ins_i |-> (rd_valid_i && rd_ctrl_i && rd_data_i == SKIP)); // R5
  AST_INS_BELOW_TH: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    ins_i |-> $past(rd_occ_i <= PW'(LO_TH) && rd_occ_i != '0)); // R5
  AST_NO_OVERFLOW_WRAP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_occ_i <= PW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i); // R7
  AST_UNF_STICKY: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    unf_i |=> unf_i); // R8
  AST_RESET_QUIET: assert property (@(posedge rd_clk_i)
    !rst_ni |-> !(rd_valid_i || ins_i || unf_i)); // R1
endmodule

bind skip_rate_match skip_rate_match_chk #(
  .PW(PW), .DEPTH(DEPTH), .LO_TH(LO_TH), .HI_TH(HI_TH), .SKIP(SKIP_SYM)
) u_chk (
  .wr_clk_i, .rd_clk_i, .rst_ni, .wr_data_i, .wr_ctrl_i,
  .rd_data_i(rd_data_o), .rd_ctrl_i(rd_ctrl_o), .rd_valid_i(rd_valid_o),
  .ins_i(ins_o), .del_i(del_o), .ovf_i(ovf_o), .unf_i(unf_o),
  .wr_occ_i(wr_occ), .rd_occ_i(rd_occ)
);

// File: tb/tb_skip_rate_match.sv
// Time unit is 1 ps: read clock half period 2000 -> 250 MHz.
module tb_skip_rate_match;
  localparam logic [7:0] SKIP = 8'h1C;

  logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [7:0] wr_data = SKIP;
  logic       wr_ctrl = 1'b1;
  logic [7:0] rd_data;
  logic       rd_ctrl, rd_valid, ins, del, ovf, unf;

  int wr_half = 2000;
  int checks = 0, errors = 0;
  int ins_cnt = 0, del_cnt = 0, match_cnt = 0, valid_cnt = 0, gap_cnt = 0;
  bit mon_en = 0, sb_en = 0, done = 0;
  logic [8:0] exp_q[$];

  skip_rate_match dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_data_i(wr_data), .wr_ctrl_i(wr_ctrl),
    .rd_data_o(rd_data), .rd_ctrl_o(rd_ctrl), .rd_valid_o(rd_valid),
    .ins_o(ins), .del_o(del), .ovf_o(ovf), .unf_o(unf)
  );

  initial forever #2000 rd_clk = ~rd_clk;
  initial forever #(wr_half) wr_clk = ~wr_clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard on the read side
  always @(negedge rd_clk) begin
    if (rst_n && mon_en) begin
      if (ins) ins_cnt++;
      if (rd_valid) valid_cnt++;
      else if (valid_cnt > 0) gap_cnt++;
      if (rd_valid && sb_en && !(rd_ctrl && rd_data == SKIP)) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected symbol actual=%h expected=none", {rd_ctrl, rd_data});
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if ({rd_ctrl, rd_data} !== e) begin
            errors++;
            $display("FAIL R2/R3 actual=%h expected=%h", {rd_ctrl, rd_data}, e);
          end else match_cnt++;
        end
      end
    end
  end

  always @(negedge wr_clk)
    if (rst_n && mon_en && del) del_cnt++;

  // driver: one symbol per write cycle, non-skips pushed to the scoreboard
  task automatic drive(input int n, input int skip_every);
    for (int k = 0; k < n; k++) begin
      logic [8:0] s;
      if (skip_every > 0 && (k % skip_every) == skip_every - 1) s = {1'b1, SKIP};
      else if (k % 37 == 5) s = {1'b1, 8'hBC};      // other control symbol
      else if (k % 41 == 7) s = {1'b0, SKIP};       // data lookalike, not a skip
      else s = {1'b0, 8'(k)};
      @(negedge wr_clk);
      {wr_ctrl, wr_data} = s;
      if (sb_en && !(s[8] && s[7:0] == SKIP)) exp_q.push_back(s);
    end
    @(negedge wr_clk);
    {wr_ctrl, wr_data} = {1'b1, SKIP};
    mon_en = 0;
  endtask

  task automatic do_reset(input int half);
    rst_n = 0;
    wr_half = half;
    {wr_ctrl, wr_data} = {1'b1, SKIP};
    repeat (4) @(negedge rd_clk);
    exp_q.delete();
    ins_cnt = 0; del_cnt = 0; match_cnt = 0; valid_cnt = 0; gap_cnt = 0;
    rst_n = 1;
    mon_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge rd_clk);
    // R1: reset state
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(ins == 0 && del == 0, "R1 pulses", ins | del, 0);
    chk(ovf == 0 && unf == 0, "R1 sticky", ovf | unf, 0);

    // Phase A: write side 0.5 % faster, skips every 10
    do_reset(1990);
    sb_en = 1;
    fork
      drive(3000, 10);
      begin
        repeat (5) @(negedge rd_clk);
        chk(rd_valid == 0, "R6 idle before fill", rd_valid, 0);
      end
    join
    chk(valid_cnt > 0, "R6 read started", valid_cnt, 1);
    chk(del_cnt > 0, "R4 deletions seen", del_cnt, 1);
    chk(match_cnt > 2000, "R2 symbols delivered", match_cnt, 2000);
    chk(ovf == 0 && unf == 0, "R7/R8 no errors phase A", ovf | unf, 0);

    // Phase B: read side 0.5 % faster
    do_reset(2010);
    drive(3000, 10);
    chk(ins_cnt > 0, "R5 insertions seen", ins_cnt, 1);
    chk(match_cnt > 2000, "R2 symbols delivered B", match_cnt, 2000);
    chk(ovf == 0 && unf == 0, "R7/R8 no errors phase B", ovf | unf, 0);

    // Phase C: write 10 % faster, no skips
    sb_en = 0;
    do_reset(1800);
    drive(1000, 0);
    chk(ovf == 1, "R7 overflow set", ovf, 1);
    chk(del_cnt == 0, "R3 no deletion of non-skip", del_cnt, 0);
    chk(unf == 0, "R8 no underflow phase C", unf, 0);
    mon_en = 1;
    drive(200, 10);
    chk(ovf == 1, "R7 overflow sticky", ovf, 1);

    // Phase D: read 10 % faster, no skips
    sb_en = 1;
    do_reset(2200);
    drive(1000, 0);
    chk(unf == 1, "R8 underflow set", unf, 1);
    chk(gap_cnt > 0, "R8 valid low when empty", gap_cnt, 1);
    chk(ins_cnt == 0, "R3 no insertion without skip", ins_cnt, 0);
    chk(ovf == 0, "R7 no overflow phase D", ovf, 0);
    chk(match_cnt > 500, "R2 order kept through underflow", match_cnt, 500);
    repeat (20) @(negedge rd_clk);
    chk(unf == 1, "R8 underflow sticky", unf, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rd_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule